// File: doc/BRIEF.md
# Alternating TX/EC Write Steering Controller

This block sits between a host and the two transmit-side channels of a converter front end. One channel is the main transmit (TX) channel and the other is the echo-cancel (EC) channel. The host writes an 8-bit control register. Besides a one-shot synchronization command, the register holds three static controls: a FIFO enable, a bypass for the EC digital high-pass filter, and a request to park the EC outputs at a weakly driven mid-supply level.

Data samples come in on a 16-bit bus, each marked by a write strobe. Until a synchronization command is accepted, strobes are ignored. A command is accepted only while the one-write-enable input is high. It fixes the phase of a strict alternation: the next strobe goes to TX, the one after that goes to EC, and the pattern then repeats. Each routed strobe gives a one-cycle valid pulse on its channel, together with the captured sample. The steering state machine has three states:

- `ST_IDLE`: not synchronized.
- `ST_EXP_TX`: the next strobe goes to TX.
- `ST_EXP_EC`: the next strobe goes to EC.

It has these transitions:

- `T_ARM`: from any state to `ST_EXP_TX` when a command is accepted.
- `T_TX`: from `ST_EXP_TX` to `ST_EXP_EC` on a strobe.
- `T_EC`: from `ST_EXP_EC` to `ST_EXP_TX` on a strobe.
- `T_RST`: to `ST_IDLE` on reset.

Top module: `txec_steer`

## Requirements
- R1: After reset the control register reads 0x00, both valid outputs are low, all control outputs are low, and the steering is unsynchronized.
- R2: The register field positions are fixed. Bit 0 is the sync command, bit 1 is the FIFO enable, bit 2 is the EC high-pass bypass, and bit 3 is the mid-supply hold request. Bits 7:4 always read 0. Bit 0 clears itself and always reads back as 0.
- R3: A write with bit 0 set synchronizes the steering only if `one_wen` is high in that cycle. Otherwise the command has no effect on the steering.
- R4: While unsynchronized, strobes produce no valid pulse on either channel.
- R5: The first strobe after synchronization gives `tx_valid` high for exactly the following cycle, with `tx_data` equal to the strobed sample.
- R6: Strobes alternate strictly. The strobe after a TX strobe goes to EC, with `ec_valid` and `ec_data` behaving as in R5. The strobe after an EC strobe goes back to TX.
- R7: An accepted sync command in any phase restarts the alternation at TX.
- R8: A strobe in the same cycle as an accepted sync command is dropped. No valid pulse follows it, and the next strobe goes to TX.
- R9: `fifo_en` and `ec_hpf_bypass` follow bits 1 and 2 of the register.
- R10: Bit 3 is stored regardless of `ec_pwrdn`. `ec_midsup_hold` is high only while bit 3 is set and `ec_pwrdn` is high.
- R11: The register contents change only on a host write. Changes on `ec_pwrdn` leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register readback |
| one_wen | input | 1 | Enables acceptance of the sync command |
| ec_pwrdn | input | 1 | EC channel is powered down |
| wr_stb | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample data |
| tx_valid | output | 1 | One-cycle TX load pulse |
| tx_data | output | 16 | Last sample routed to TX |
| ec_valid | output | 1 | One-cycle EC load pulse |
| ec_data | output | 16 | Last sample routed to EC |
| fifo_en | output | 1 | FIFO enable control |
| ec_hpf_bypass | output | 1 | EC high-pass filter bypass control |
| ec_midsup_hold | output | 1 | EC outputs parked at mid-supply |

## Verification
The assertions assume that `wr_stb`, `host_wr` and the sample bus are synchronous to `clk`, and that `ec_pwrdn` and `one_wen` are stable around the clock edge. The bench keeps to this by changing every input only on the falling edge. The alternation checks also assume that a strobe lasts one cycle per sample. The stimulus table therefore never holds `wr_stb` high for a sample it means to route twice. Where two strobes fall in consecutive cycles, each one is counted as a separate sample.

// File: rtl/txec_pkg.sv
package txec_pkg;
    localparam int CTRL_W   = 8;
    localparam int ARM_BIT  = 0;
    localparam int FIFO_BIT = 1;
    localparam int BYP_BIT  = 2;
    localparam int MID_BIT  = 3;
    localparam int N_CHAN   = 2;
    localparam int CH_TX    = 0;
    localparam int CH_EC    = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXP_TX = 2'd1,
        ST_EXP_EC = 2'd2
    } steer_state_t;
endpackage

// File: rtl/txec_ctrl_reg.sv
module txec_ctrl_reg
    import txec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              one_wen,
    output logic [CTRL_W-1:0] host_rdata,
    output logic              arm,
    output logic              fifo_bit,
    output logic              byp_bit,
    output logic              mid_bit
);
    localparam int STORE_LO = FIFO_BIT;
    localparam int STORE_HI = MID_BIT;
    localparam int STORE_W  = STORE_HI - STORE_LO + 1;

    logic [STORE_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (host_wr) begin
            store_q <= host_wdata[STORE_HI:STORE_LO];
        end
    end

    always_comb begin
        arm = host_wr && host_wdata[ARM_BIT] && one_wen;
        host_rdata = '0;
        host_rdata[STORE_HI:STORE_LO] = store_q;
        fifo_bit = store_q[FIFO_BIT-STORE_LO];
        byp_bit  = store_q[BYP_BIT-STORE_LO];
        mid_bit  = store_q[MID_BIT-STORE_LO];
    end

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(host_rdata));
endmodule

// File: rtl/txec_steer_fsm.sv
module txec_steer_fsm
    import txec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              ec_valid,
    output logic [DATA_W-1:0] ec_data
);
    steer_state_t state_q, state_d;
    logic [N_CHAN-1:0]  load;
    logic [N_CHAN-1:0]  vld_q;
    logic [DATA_W-1:0]  dat_q [N_CHAN];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = '0;
        if (arm) begin
            state_d = ST_EXP_TX;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_EXP_TX: if (wr_stb) begin
                    load[CH_TX] = 1'b1;
                    state_d = ST_EXP_EC;
                end
                ST_EXP_EC: if (wr_stb) begin
                    load[CH_EC] = 1'b1;
                    state_d = ST_EXP_TX;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[c] <= 1'b0;
                dat_q[c] <= '0;
            end else begin
                vld_q[c] <= load[c];
                if (load[c]) dat_q[c] <= wr_data;
            end
        end
    end

    assign tx_valid = vld_q[CH_TX];
    assign ec_valid = vld_q[CH_EC];
    assign tx_data  = dat_q[CH_TX];
    assign ec_data  = dat_q[CH_EC];

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (!tx_valid && !ec_valid));
    // R5
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXP_TX && wr_stb && !arm) |=> (tx_valid && tx_data == $past(wr_data)));
    // R6
    alt_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (state_q == ST_EXP_EC || $past(arm)));
    // R6
    alt_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_valid |-> (state_q == ST_EXP_TX));
    // R8
    arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!tx_valid && !ec_valid && state_q == ST_EXP_TX));
endmodule

// File: rtl/txec_steer.sv
module txec_steer
    import txec_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              one_wen,
    input  logic              ec_pwrdn,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              ec_valid,
    output logic [DATA_W-1:0] ec_data,
    output logic              fifo_en,
    output logic              ec_hpf_bypass,
    output logic              ec_midsup_hold
);
    logic arm, mid_bit;

    txec_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .one_wen    (one_wen),
        .host_rdata (host_rdata),
        .arm        (arm),
        .fifo_bit   (fifo_en),
        .byp_bit    (ec_hpf_bypass),
        .mid_bit    (mid_bit)
    );

    txec_steer_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .ec_valid (ec_valid),
        .ec_data  (ec_data)
    );

    assign ec_midsup_hold = mid_bit && ec_pwrdn;

    // R10
    midsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_midsup_hold |-> ec_pwrdn);
    // R6
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && ec_valid));
endmodule

// File: tb/txec_steer_bench.sv
module txec_steer_bench;
    typedef struct packed {
        logic        wr;
        logic [7:0]  wd;
        logic        owe;
        logic        pd;
        logic        stb;
        logic [15:0] d;
        logic        xtv;
        logic        xev;
        logic [15:0] xd;
        logic [7:0]  xrd;
        logic        xmid;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h1111, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R4 before sync
        '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R3 gated
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h2222, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R3 still idle
        '{1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R2 self clear
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hA001, 1'b1, 1'b0, 16'hA001, 8'h00, 1'b0}, // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hB002, 1'b0, 1'b1, 16'hB002, 8'h00, 1'b0}, // R6 EC
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hA003, 1'b1, 1'b0, 16'hA003, 8'h00, 1'b0}, // R6 back to TX
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R5 pulse ends
        '{1'b1, 8'h03, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h02, 1'b0}, // R7 rearm in EC phase
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hC004, 1'b1, 1'b0, 16'hC004, 8'h02, 1'b0}, // R7 TX first
        '{1'b1, 8'h0A, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h0A, 1'b0}, // R10 stored, pd low
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h0A, 1'b1}, // R10 pd high
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h0A, 1'b0}, // R11 retained
        '{1'b1, 8'h01, 1'b1, 1'b0, 1'b1, 16'hD005, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0}, // R8 dropped
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'hE006, 1'b1, 1'b0, 16'hE006, 8'h00, 1'b0}, // R8 TX next
        '{1'b1, 8'hF4, 1'b0, 1'b0, 1'b1, 16'hE007, 1'b0, 1'b1, 16'hE007, 8'h04, 1'b0}  // R2 R9 reserved, EC
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        one_wen = 1'b0;
    logic        ec_pwrdn = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tx_valid, ec_valid, fifo_en, ec_hpf_bypass, ec_midsup_hold;
    logic [15:0] tx_data, ec_data;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    txec_steer u_txec_steer (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .one_wen(one_wen), .ec_pwrdn(ec_pwrdn),
        .wr_stb(wr_stb), .wr_data(wr_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .ec_valid(ec_valid), .ec_data(ec_data), .fifo_en(fifo_en),
        .ec_hpf_bypass(ec_hpf_bypass), .ec_midsup_hold(ec_midsup_hold)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        host_wr = v.wr; host_wdata = v.wd; one_wen = v.owe;
        ec_pwrdn = v.pd; wr_stb = v.stb; wr_data = v.d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1 rdata", {8'h00, host_rdata}, 16'h0000);
        check("R1 valids", {14'd0, tx_valid, ec_valid}, 16'h0000);
        check("R1 controls", {13'd0, fifo_en, ec_hpf_bypass, ec_midsup_hold}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("R5 R6 tx_valid step %0d", i), {15'd0, tx_valid}, {15'd0, VECS[i].xtv});
            check($sformatf("R6 ec_valid step %0d", i), {15'd0, ec_valid}, {15'd0, VECS[i].xev});
            if (VECS[i].xtv) check($sformatf("R5 tx_data step %0d", i), tx_data, VECS[i].xd);
            if (VECS[i].xev) check($sformatf("R6 ec_data step %0d", i), ec_data, VECS[i].xd);
            check($sformatf("R2 R11 rdata step %0d", i), {8'h00, host_rdata}, {8'h00, VECS[i].xrd});
            check($sformatf("R9 fifo step %0d", i), {15'd0, fifo_en}, {15'd0, VECS[i].xrd[1]});
            check($sformatf("R9 bypass step %0d", i), {15'd0, ec_hpf_bypass}, {15'd0, VECS[i].xrd[2]});
            check($sformatf("R10 midsup step %0d", i), {15'd0, ec_midsup_hold}, {15'd0, VECS[i].xmid});
        end

        // R1: reset in the middle of the alternation returns to unsynchronized
        drive('{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h5A5A, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0});
        check("R6 TX after EC", {15'd0, tx_valid}, 16'd1);
        @(negedge clk);
        wr_stb = 1'b0; host_wr = 1'b1; host_wdata = 8'h0E;
        @(negedge clk);
        host_wr = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 rdata after reset", {8'h00, host_rdata}, 16'h0000);
        drive('{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h7777, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0});
        check("R1 R4 no TX after reset", {15'd0, tx_valid}, 16'd0);
        check("R1 R4 no EC after reset", {15'd0, ec_valid}, 16'd0);
        @(negedge clk) wr_stb = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule